// File: doc/BRIEF.md
# Receive Channel Activation Sequencer

This block brings one idle receive channel of a time-division-multiplexed receiver into service. A request names the channel, a 64-bit initialization pattern and the buffer-count field that describes how the receive local memory is split. The sequencer first reads the channel's active flag from an external per-channel flag register. It then writes the pattern into the channel's 8-byte slot in every receive buffer, one 64-bit word per cycle, and only after that pulses a set strobe so the channel's flag becomes 1. A flag value of 1 means the channel is active and 0 means it is inactive.

The local memory always holds 256 slots of 8 bytes. The buffer-count field N selects N+1 buffers, so each buffer has 256/(N+1) channel slots. Channel C of buffer B sits at byte address (256/(N+1)×B + C)×8. Because N+1 is a power of two, the division is a shift.

Requests use a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request transfers on a rising edge where `req_valid` and `req_ready` are both high, and the request fields are sampled on that edge only. While a request is being processed, `req_ready` stays low and a pending request waits. The memory write port, the flag register port and the status pins have no handshake.

Top module: `rx_chan_act_seq`

## Requirements
- R1: `req_ready` is 1 exactly when the sequencer is idle. A request is accepted on the edge where `req_valid` and `req_ready` are both 1. Channel, pattern and buffer-count field are captured on that edge, and later changes to them have no effect on the request.
- R2: During the first cycle after acceptance, `act_chan` presents the requested channel and `act_bit` is sampled. `act_chan` holds that channel until the sequencer is idle again.
- R3: Only buffer-count field values 0, 1, 3, 7, 15 and 31 are legal, meaning 1, 2, 4, 8, 16 and 32 buffers. Any other value ends the request with an error.
- R4: Each write puts the captured 64-bit pattern at byte address (256/(N+1)×B + C)×8, with the low three address bits zero.
- R5: For a good request, exactly N+1 writes occur, for B = 0 up to N in increasing order, in consecutive cycles starting in the second cycle after acceptance.
- R6: `act_set` pulses for one cycle in the cycle right after the last write, with `act_chan` equal to the requested channel. It never pulses before all N+1 writes are done.
- R7: `done` pulses for one cycle in the cycle after `act_set`, and the sequencer is idle in the following cycle.
- R8: If `act_bit` is 1 during the check cycle, `err` pulses in the next cycle. No write and no `act_set` occurs for that request.
- R9: A channel number of 256/(N+1) or more ends the request with an `err` pulse and no writes.
- R10: `busy` is 1 from the cycle after acceptance through the `done` or `err` cycle. That is N+4 cycles for a good request and 2 cycles for a rejected one.
- R11: After reset the sequencer is idle: `req_ready` is 1 and `busy`, `done`, `err`, `mem_we` and `act_set` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_chan | input | 8 | Channel to activate |
| req_data | input | 64 | Initialization pattern |
| req_nbuf | input | 5 | Buffer-count field N (buffers minus one) |
| mem_we | output | 1 | Local memory write enable |
| mem_addr | output | 11 | Local memory byte address |
| mem_wdata | output | 64 | Local memory write data |
| act_chan | output | 8 | Channel index into the active-flag register |
| act_bit | input | 1 | Active flag of `act_chan` |
| act_set | output | 1 | Set strobe for the flag of `act_chan` |
| busy | output | 1 | Request in progress |
| done | output | 1 | Activation finished (one-cycle pulse) |
| err | output | 1 | Request rejected (one-cycle pulse) |

## Verification
The bench targets the extremes of the buffer count. With one buffer and channel 255, a wrong shift would wrap the address into another slot. With 32 buffers and channel 7, a stride bug would scatter the 32 writes, and channel 8 is the first channel that must be rejected. It also sends illegal field values such as 2 and 5, which a design that only checks the range would accept and then write to the wrong stride. It sends channels whose flag is already set, which a design that checks the flag too late would still write into memory. On every request the bench counts the writes before the set strobe, so a design that raises the flag early or stops one buffer short shows up. It also changes the request fields right after the handshake, which exposes a design that reads the live inputs instead of the captured ones.

// File: rtl/rcas_pkg.sv
package rcas_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_CHECK = 3'd1,
    SQ_WRITE = 3'd2,
    SQ_SETF  = 3'd3,
    SQ_FIN   = 3'd4,
    SQ_REJ   = 3'd5
  } seq_state_e;

endpackage

// File: rtl/rcas_cfg_check.sv
// Validates the buffer-count field and the channel number, and derives
// log2(buffers) used as the shift amount by the address generator.
module rcas_cfg_check #(
  parameter int SLOT_W = 8,
  parameter int NB_W   = 5,
  localparam int SH_W  = $clog2(NB_W + 1)
) (
  input  logic [NB_W-1:0]   nbuf,
  input  logic [SLOT_W-1:0] chan,
  output logic              nbuf_ok,
  output logic              chan_ok,
  output logic [SH_W-1:0]   shift
);

  // A legal field is a run of ones starting at bit 0: each set bit needs
  // the bit below it set as well.
  logic [NB_W-1:0] bit_ok;

  assign bit_ok[0] = 1'b1;

  genvar gi;
  generate
    for (gi = 1; gi < NB_W; gi++) begin : g_run
      assign bit_ok[gi] = ~nbuf[gi] | nbuf[gi-1];
    end
  endgenerate

  assign nbuf_ok = &bit_ok;

  // For a legal field, the number of ones is log2(buffers).
  always_comb begin
    shift = '0;
    for (int i = 0; i < NB_W; i++) begin
      shift = shift + SH_W'(nbuf[i]);
    end
  end

  // The channel must fit inside one buffer, which holds 2^(SLOT_W-shift) slots.
  assign chan_ok = ((chan >> (SLOT_W - int'(shift))) == '0);

endmodule

// File: rtl/rcas_addr_gen.sv
// Slot address: (TOTAL/(N+1))*B + C, scaled to bytes. The division is a
// left shift of the buffer index by (SLOT_W - log2(N+1)).
module rcas_addr_gen #(
  parameter int SLOT_W  = 8,
  parameter int NB_W    = 5,
  parameter int BOFF_W  = 3,
  localparam int SH_W   = $clog2(NB_W + 1),
  localparam int ADDR_W = SLOT_W + BOFF_W
) (
  input  logic [SLOT_W-1:0] chan,
  input  logic [NB_W-1:0]   bidx,
  input  logic [SH_W-1:0]   shift,
  output logic [ADDR_W-1:0] byte_addr
);

  logic [SLOT_W-1:0] base;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    base = SLOT_W'(bidx) << (SLOT_W - int'(shift));
    slot = base + chan;
  end

  assign byte_addr = {slot, {BOFF_W{1'b0}}};

endmodule

// File: rtl/rcas_fsm.sv
// Sequencer control: idle -> check -> write loop -> set flag -> done.
// A rejected request goes from check to the reject state instead.
module rcas_fsm
  import rcas_pkg::*;
#(
  parameter int NB_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            cfg_ok,
  input  logic            act_bit,
  input  logic [NB_W-1:0] nbuf_q,
  output logic            req_ready,
  output logic            busy,
  output logic            wr_en,
  output logic            set_en,
  output logic            fin,
  output logic            rej,
  output logic [NB_W-1:0] bidx
);

  seq_state_e      state_q, state_d;
  logic [NB_W-1:0] bidx_q, bidx_d;
  logic            last_buf;

  assign last_buf = (bidx_q == nbuf_q);

  always_comb begin
    state_d = state_q;
    bidx_d  = bidx_q;
    unique case (state_q)
      SQ_IDLE: begin
        bidx_d = '0;
        if (req_valid) state_d = SQ_CHECK;
      end
      SQ_CHECK: begin
        bidx_d = '0;
        if (!cfg_ok || act_bit) state_d = SQ_REJ;
        else                    state_d = SQ_WRITE;
      end
      SQ_WRITE: begin
        if (last_buf) state_d = SQ_SETF;
        else          bidx_d  = bidx_q + 1'b1;
      end
      SQ_SETF: state_d = SQ_FIN;
      SQ_FIN:  state_d = SQ_IDLE;
      SQ_REJ:  state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      bidx_q  <= '0;
    end else begin
      state_q <= state_d;
      bidx_q  <= bidx_d;
    end
  end

  assign req_ready = (state_q == SQ_IDLE);
  assign busy      = (state_q != SQ_IDLE);
  assign wr_en     = (state_q == SQ_WRITE);
  assign set_en    = (state_q == SQ_SETF);
  assign fin       = (state_q == SQ_FIN);
  assign rej       = (state_q == SQ_REJ);
  assign bidx      = bidx_q;

  // An accepted request always enters the check cycle next.
  p_accept_check_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (state_q == SQ_CHECK));

  // Consecutive writes step the buffer index by exactly one.
  p_buf_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (bidx_q == $past(bidx_q) + 1'b1));

  // The first write of a request is to buffer 0.
  p_first_buf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> (bidx_q == '0));

  // The flag is set only right after the write to the last buffer.
  p_set_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> ($past(wr_en) && ($past(bidx_q) == nbuf_q)));

  // Completion follows the set strobe directly.
  p_fin_after_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> $past(set_en));

endmodule

// File: rtl/rx_chan_act_seq.sv
module rx_chan_act_seq
  import rcas_pkg::*;
#(
  parameter int SLOT_W   = 8,
  parameter int NB_W     = 5,
  parameter int DATA_W   = 64,
  localparam int BOFF_W  = $clog2(DATA_W / 8),
  localparam int ADDR_W  = SLOT_W + BOFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SLOT_W-1:0] req_chan,
  input  logic [DATA_W-1:0] req_data,
  input  logic [NB_W-1:0]   req_nbuf,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [SLOT_W-1:0] act_chan,
  input  logic              act_bit,
  output logic              act_set,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int SH_W = $clog2(NB_W + 1);

  logic [SLOT_W-1:0] chan_q;
  logic [DATA_W-1:0] data_q;
  logic [NB_W-1:0]   nbuf_q;
  logic              accept;
  logic              nbuf_ok, chan_ok;
  logic [SH_W-1:0]   shift;
  logic [NB_W-1:0]   bidx;

  assign accept = req_valid && req_ready;

  // Request fields are captured once, on the accepting edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      data_q <= '0;
      nbuf_q <= '0;
    end else if (accept) begin
      chan_q <= req_chan;
      data_q <= req_data;
      nbuf_q <= req_nbuf;
    end
  end

  rcas_cfg_check #(.SLOT_W(SLOT_W), .NB_W(NB_W)) u_cfg (
    .nbuf    (nbuf_q),
    .chan    (chan_q),
    .nbuf_ok (nbuf_ok),
    .chan_ok (chan_ok),
    .shift   (shift)
  );

  rcas_fsm #(.NB_W(NB_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .cfg_ok    (nbuf_ok && chan_ok),
    .act_bit   (act_bit),
    .nbuf_q    (nbuf_q),
    .req_ready (req_ready),
    .busy      (busy),
    .wr_en     (mem_we),
    .set_en    (act_set),
    .fin       (done),
    .rej       (err),
    .bidx      (bidx)
  );

  rcas_addr_gen #(.SLOT_W(SLOT_W), .NB_W(NB_W), .BOFF_W(BOFF_W)) u_addr (
    .chan      (chan_q),
    .bidx      (bidx),
    .shift     (shift),
    .byte_addr (mem_addr)
  );

  assign mem_wdata = data_q;
  assign act_chan  = chan_q;

  // Writes are always slot-aligned.
  p_slot_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[BOFF_W-1:0] == '0));

  // No write is ever issued under an illegal buffer-count field.
  p_legal_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> nbuf_ok);

  // No write is ever issued for a channel outside one buffer.
  p_chan_fits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> chan_ok);

  // A rejection is preceded by neither a write nor a set strobe.
  p_reject_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(busy) && !$past(mem_we) && !$past(act_set)));

  // The captured channel does not move while a request is in flight.
  p_chan_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(act_chan));

  // At most one of the action/status pulses in any cycle.
  p_one_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, act_set, done, err}));

  // The handshake is open only when nothing is in flight.
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);

endmodule

// File: tb/tb_rx_chan_act_seq.sv
`timescale 1ns/1ps
module tb_rx_chan_act_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_chan = '0;
  logic [63:0] req_data = '0;
  logic [4:0]  req_nbuf = '0;
  logic        mem_we;
  logic [10:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [7:0]  act_chan;
  logic        act_bit;
  logic        act_set;
  logic        busy, done, err;

  always #2.5 clk = ~clk;

  rx_chan_act_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_data(req_data), .req_nbuf(req_nbuf),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .act_chan(act_chan), .act_bit(act_bit), .act_set(act_set),
    .busy(busy), .done(done), .err(err)
  );

  // External models: local memory and active-flag register.
  logic [63:0]  mem     [256];
  logic [63:0]  exp_mem [256];
  logic [255:0] act;
  logic [255:0] exp_act;
  assign act_bit = act[act_chan];

  int checks = 0;
  int fails  = 0;

  // Monitor records per-request activity at the falling edge.
  int          wr_cnt, set_cnt, set_at_wr, done_cnt, err_cnt, busy_cnt, cyc;
  logic [10:0] wr_addr [64];
  logic [63:0] wr_data [64];
  int          wr_cyc  [64];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (busy) busy_cnt = busy_cnt + 1;
      if (done) done_cnt = done_cnt + 1;
      if (err)  err_cnt  = err_cnt + 1;
      if (mem_we) begin
        if (wr_cnt < 64) begin
          wr_addr[wr_cnt] = mem_addr;
          wr_data[wr_cnt] = mem_wdata;
          wr_cyc[wr_cnt]  = cyc;
        end
        mem[mem_addr[10:3]] = mem_wdata;
        wr_cnt = wr_cnt + 1;
      end
      if (act_set) begin
        act[act_chan] = 1'b1;
        set_cnt   = set_cnt + 1;
        set_at_wr = wr_cnt;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint got, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, expv);
    end
  endtask

  function automatic int slot_of(int n, int b, int c);
    return (256 / (n + 1)) * b + c;
  endfunction

  function automatic bit legal_n(int n);
    return (n == 0) || (n == 1) || (n == 3) || (n == 7) || (n == 15) || (n == 31);
  endfunction

  task automatic do_req(input int c, input int n, input logic [63:0] d);
    bit ok_exp;
    bit seq_ok;
    int t;
    int bad;
    ok_exp = legal_n(n) && (c < 256 / (n + 1)) && !act[c];
    @(negedge clk); #1;
    wr_cnt = 0; set_cnt = 0; set_at_wr = -1; done_cnt = 0; err_cnt = 0; busy_cnt = 0;
    chk(req_ready === 1'b1, "R1", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_chan = 8'(c); req_data = d; req_nbuf = 5'(n);
    @(negedge clk); #1;
    // R1: scramble the fields after the accepting edge; they must be ignored
    req_valid = 1'b0; req_chan = ~8'(c); req_data = ~d; req_nbuf = ~5'(n);
    chk(act_chan == 8'(c), "R2", "act_chan in check cycle", act_chan, c);
    t = 0;
    while (done_cnt == 0 && err_cnt == 0 && t < 80) begin
      @(negedge clk); #1; t++;
    end
    @(negedge clk); #1;
    if (ok_exp) begin
      for (int b = 0; b <= n; b++) exp_mem[slot_of(n, b, c)] = d;
      exp_act[c] = 1'b1;
      chk(done_cnt == 1 && err_cnt == 0, "R7", "done pulses", done_cnt, 1);
      chk(wr_cnt == n + 1, "R5", "write count", wr_cnt, n + 1);
      seq_ok = 1'b1;
      bad = -1;
      for (int b = 0; b <= n && b < 64; b++) begin
        if (wr_addr[b] != 11'(slot_of(n, b, c) * 8) || wr_data[b] != d) begin
          seq_ok = 1'b0;
          if (bad < 0) bad = b;
        end
        if (wr_cyc[b] != wr_cyc[0] + b) seq_ok = 1'b0;
      end
      chk(seq_ok, "R4", "write address/data order",
          (bad >= 0) ? longint'(wr_addr[bad]) : 0,
          (bad >= 0) ? longint'(slot_of(n, bad, c) * 8) : 0);
      chk(set_cnt == 1 && set_at_wr == n + 1, "R6", "set after all writes",
          set_at_wr, n + 1);
      chk(busy_cnt == n + 4, "R10", "busy cycles", busy_cnt, n + 4);
    end else begin
      chk(err_cnt == 1 && done_cnt == 0, legal_n(n) ? "R8" : "R3", "err pulses", err_cnt, 1);
      chk(wr_cnt == 0 && set_cnt == 0, "R9", "no write on reject", wr_cnt, 0);
      chk(busy_cnt == 2, "R10", "busy cycles on reject", busy_cnt, 2);
    end
    chk(act == exp_act, "R6", "flag register", act[c], exp_act[c]);
    bad = -1;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i] && bad < 0) bad = i;
    chk(bad < 0, "R4", "memory image slot", bad, -1);
    chk(req_ready === 1'b1 && busy === 1'b0, "R7", "idle after end", busy, 0);
  endtask

  initial begin
    int n, c, k, mx;
    logic [63:0] d;
    void'($urandom(32'd917));
    cyc = 0; wr_cnt = 0; set_cnt = 0; done_cnt = 0; err_cnt = 0; busy_cnt = 0;
    set_at_wr = -1;
    act = '0; exp_act = '0;
    for (int i = 0; i < 256; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && busy === 1'b0 && done === 1'b0 && err === 1'b0 &&
        mem_we === 1'b0 && act_set === 1'b0, "R11", "outputs in reset",
        {req_ready, busy, done, err, mem_we, act_set}, 6'b100000);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready === 1'b1 && busy === 1'b0, "R11", "idle after reset", busy, 0);

    // Directed corners
    do_req(255, 0, 64'h0123_4567_89AB_CDEF);   // one buffer, top channel
    do_req(7, 31, 64'hDEAD_BEEF_0000_0007);    // 32 buffers, last fitting channel
    do_req(8, 31, 64'h1111_2222_3333_4444);    // R9: first channel past the buffer
    do_req(3, 2, 64'hAAAA_5555_AAAA_5555);     // R3: illegal field
    do_req(3, 5, 64'h5555_AAAA_5555_AAAA);     // R3: illegal field
    do_req(7, 31, 64'hFFFF_0000_FFFF_0000);    // R8: flag already set
    act[100] = 1'b1; exp_act[100] = 1'b1;
    do_req(100, 1, 64'h0BAD_F00D_0BAD_F00D);   // R8: preset flag
    do_req(127, 1, 64'hCAFE_CAFE_CAFE_CAFE);   // two buffers, top channel
    do_req(31, 7, 64'h7777_8888_9999_AAAA);    // eight buffers

    // Constrained random
    for (int it = 0; it < 40; it++) begin
      if (it % 10 == 0) begin act = '0; exp_act = '0; end
      if ($urandom_range(7) == 0) begin
        do n = $urandom_range(31); while (legal_n(n));
      end else begin
        k = $urandom_range(5);
        n = (1 << k) - 1;
      end
      mx = 256 / (n + 1);
      if ($urandom_range(7) == 0 && mx < 256) c = mx + $urandom_range(255 - mx);
      else c = $urandom_range(mx - 1);
      if ($urandom_range(5) == 0) begin act[c] = 1'b1; exp_act[c] = 1'b1; end
      d = {$urandom, $urandom};
      do_req(c, n, d);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule